// File: doc/BRIEF.md
# Serial Register-Access Slave with Exact-Length Framing

This block is the serial front end of a motor-driver register file. A host selects it with an active-low select line, clocks in 16-bit packets MSB first on the rising edge of the serial clock, and receives read data on a return line. Two packet kinds exist. A packet whose two leading bits are both 1 is a control access: it carries a read/write flag, a 5-bit offset into the upper control bank and one data byte. Any other packet is a write to a 12-bit converter register, addressed by its leading nibble.

The serial pins are brought into the system clock domain and edge-detected there. A packet counts only when exactly 16 serial clocks were seen while the select line was low. Accepted writes are handed to the register file through a valid/ready port. A lock register held inside the block blocks every write except writes to the lock register itself. Read data and an optional status byte are returned on the second byte of the frame. Two timing modes are available for this return: a normal one and one advanced by half a serial clock. An idle-bus watchdog with three selectable windows reports when the host has gone silent.

Top module: `drv_spi_slave`

## Requirements
- R1: While `ssz_n` is low, `simo` is taken on each rising `sclk`, MSB first. A packet with exactly 16 rising edges is accepted, and its write appears on the write port shortly after `ssz_n` returns high.
- R2: A select period with any count of rising `sclk` edges other than 16 (for example 15 or 17) produces no write.
- R3: Packet bits [15:14] = 2'b11 mark a control packet. Bit 13 is the read flag (1 = read). Bits [12:8] are an offset mapped to address 0x60 + offset, and bits [7:0] are the data. Any other value marks a converter packet, with `wr_dac` = 1, `wr_addr` = bits [15:12] and `wr_data` = bits [11:0].
- R4: After reset the block is locked and drops every write. A control write to offset 0x16 is never forwarded; its bit 7 sets (1) or clears (0) the lock-release bit. A control read of offset 0x16 returns that bit in bit 7 and zero in the other bits.
- R5: For a control read, `rd_addr` holds 0x60 + offset. `rd_data` is returned MSB first on `somi`, driven (`somi_oe` = 1) from the 8th falling `sclk` edge, so that the host takes one bit on each of rising edges 9 to 16. `somi_oe` is 0 while the bus is idle.
- R6: With `cfg_adv_rd` = 1, the return byte is driven from just after the 8th rising edge, and each later bit changes on a rising edge. The byte taken on rising edges 9 to 16 is the same as in normal mode.
- R7: With `cfg_stat_on_focus` = 1, a converter write to address 2 returns `status_i` on `somi` in the same way as a read, and the write is still committed. A converter write to any other address, or with the option off, leaves `somi_oe` at 0.
- R8: `somi_pd_en` equals `cfg_idle_pull` whenever `somi_oe` is 0, and is 0 while `somi_oe` is 1.
- R9: `wr_valid`, `wr_addr`, `wr_data` and `wr_dac` stay unchanged until `wr_ready` is seen. A packet accepted while an earlier write is still waiting is dropped.
- R10: `cfg_wd_sel` chooses the watchdog window: 0 off, 1 long, 2 medium, 3 short, in clock cycles given by parameters. After that many cycles of idle bus, `wd_expire` pulses for one cycle. Any select period restarts the count, and with setting 0 it never pulses.
- R11: A control read packet never produces a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssz_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| simo | input | 1 | Serial data from host |
| somi | output | 1 | Serial data to host |
| somi_oe | output | 1 | Drive enable for `somi` |
| somi_pd_en | output | 1 | Weak pull-down enable for idle `somi` |
| cfg_adv_rd | input | 1 | Half-cycle-advanced return mode |
| cfg_stat_on_focus | input | 1 | Return status during focus converter write |
| cfg_idle_pull | input | 1 | Pull `somi` low when idle instead of floating |
| cfg_wd_sel | input | 2 | Watchdog window select |
| status_i | input | 8 | Status byte for focus-write readback |
| rd_addr | output | 7 | Register-file read address |
| rd_data | input | 8 | Register-file read data (combinational) |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Register file accepts write |
| wr_dac | output | 1 | 1 = converter write, 0 = control write |
| wr_addr | output | 7 | Write address |
| wr_data | output | 12 | Write data (control data in low byte) |
| wd_expire | output | 1 | One-cycle idle-bus timeout pulse |

## Verification
Randomly mixed converter writes, control writes and control reads are sent, with return timing switched at random. These show whether header decode separates the two packet kinds, and whether the read flag alone blocks the write. Frames of 15, 16 and 17 clocks separate the exact-count rule from off-by-one acceptance. Lock, unlock and relock sequences separate the write-protect path from the lock register's own path. Holding `wr_ready` low over two packets separates holding a waiting write from overwriting it. Idle windows just short of and just past each watchdog limit show that the window is counted from the end of the last select period.

// File: rtl/drv_spi_slave_pkg.sv
package drv_spi_slave_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_LONG  = 2'd1,
    WD_MID   = 2'd2,
    WD_SHORT = 2'd3
  } wd_sel_e;

  localparam logic [1:0] CTRL_TAG = 2'b11;

  function automatic logic is_ctrl(input logic [1:0] tag);
    return tag == CTRL_TAG;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int PKT_BITS = 16,
  parameter int HDR_BITS = 8,
  parameter int CNT_W    = $clog2(PKT_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_act,
  input  logic                sel_start,
  input  logic                sel_end,
  input  logic                clk_rise,
  input  logic                din,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic [HDR_BITS-1:0] hdr_q,
  output logic                hdr_vld,
  output logic [PKT_BITS-1:0] pkt_q,
  output logic                pkt_vld
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PKT_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_PKT = CNT_W'(PKT_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      pkt_q   <= '0;
      hdr_q   <= '0;
      hdr_vld <= 1'b0;
      pkt_vld <= 1'b0;
    end else begin
      hdr_vld <= 1'b0;
      pkt_vld <= 1'b0;
      if (sel_start) begin
        bit_cnt <= '0;
      end else if (sel_act && clk_rise) begin
        // saturate one past the packet length so overlong frames stay rejected
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < CNT_PKT) pkt_q <= {pkt_q[PKT_BITS-2:0], din};
        if (bit_cnt == CNT_HDR) begin
          hdr_q   <= {pkt_q[HDR_BITS-2:0], din};
          hdr_vld <= 1'b1;
        end
      end
      if (sel_end && bit_cnt == CNT_PKT) pkt_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_somi_tx.sv
module spi_somi_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         bit_o,
  output logic         oe_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_o <= 1'b0;
    end else if (stop) begin
      oe_o <= 1'b0;
    end else if (load) begin
      sh_q <= load_data;
      oe_o <= 1'b1;
    end else if (shift && oe_o) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[W-1];
endmodule

// File: rtl/spi_bus_wdog.sv
module spi_bus_wdog
  import drv_spi_slave_pkg::*;
#(
  parameter int LIM_LONG  = 50000,
  parameter int LIM_MID   = 5000,
  parameter int LIM_SHORT = 500,
  parameter int CW        = $clog2(LIM_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       busy,
  output logic       expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  wd_sel_e       mode;

  assign mode = wd_sel_e'(sel);

  always_comb begin
    case (mode)
      WD_LONG:  lim = CW'(LIM_LONG);
      WD_MID:   lim = CW'(LIM_MID);
      WD_SHORT: lim = CW'(LIM_SHORT);
      default:  lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (mode == WD_OFF || busy) begin
        cnt_q <= '0;
      end else if (cnt_q < lim) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == lim - 1'b1) expire <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/drv_spi_slave.sv
module drv_spi_slave
  import drv_spi_slave_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter int         DAC_W       = 12,
  parameter int         DAC_AW      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         WD_LONG     = 50000,
  parameter int         WD_MID      = 5000,
  parameter int         WD_SHORT    = 500,
  parameter logic [4:0] LOCK_OFF    = 5'h16,
  parameter logic [3:0] FOCUS_ADDR  = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ssz_n,
  input  logic              sclk,
  input  logic              simo,
  output logic              somi,
  output logic              somi_oe,
  output logic              somi_pd_en,
  input  logic              cfg_adv_rd,
  input  logic              cfg_stat_on_focus,
  input  logic              cfg_idle_pull,
  input  logic [1:0]        cfg_wd_sel,
  input  logic [DATA_W-1:0] status_i,
  output logic [6:0]        rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_dac,
  output logic [6:0]        wr_addr,
  output logic [DAC_W-1:0]  wr_data
  ,output logic             wd_expire
);
  localparam int PKT_BITS = DAC_AW + DAC_W;
  localparam int HDR_BITS = PKT_BITS - DATA_W;
  localparam int CNT_W    = $clog2(PKT_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_BITS);

  // synchronized pins: [0] select, [1] serial clock, [2] data
  logic [2:0] lvl;
  logic [1:0] prev_q;
  logic       ssz_lvl, sel_act, sel_start, sel_end, sclk_rise, sclk_fall;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({simo, sclk, ssz_n}), .lvl_o(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b01;
    else        prev_q <= lvl[1:0];
  end

  assign ssz_lvl   = lvl[0];
  assign sel_act   = ~ssz_lvl;
  assign sel_start = prev_q[0] & ~lvl[0];
  assign sel_end   = ~prev_q[0] & lvl[0];
  assign sclk_rise = ~prev_q[1] & lvl[1];
  assign sclk_fall = prev_q[1] & ~lvl[1];

  logic [CNT_W-1:0]    bit_cnt;
  logic [HDR_BITS-1:0] hdr_q;
  logic                hdr_vld;
  logic [PKT_BITS-1:0] pkt_q;
  logic                pkt_vld;

  spi_frame_rx #(.PKT_BITS(PKT_BITS), .HDR_BITS(HDR_BITS), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .sel_start(sel_start),
    .sel_end(sel_end), .clk_rise(sclk_rise), .din(lvl[2]),
    .bit_cnt(bit_cnt), .hdr_q(hdr_q), .hdr_vld(hdr_vld),
    .pkt_q(pkt_q), .pkt_vld(pkt_vld)
  );

  // header decode for the return byte
  logic              unlock_q;
  logic              hdr_ctrl, hdr_rd, hdr_stat, tx_want;
  logic [4:0]        hdr_off;
  logic [DATA_W-1:0] tx_src;
  logic              tx_load, tx_shift;

  assign hdr_ctrl = is_ctrl(hdr_q[HDR_BITS-1 -: 2]);
  assign hdr_rd   = hdr_ctrl & hdr_q[5];
  assign hdr_off  = hdr_q[4:0];
  assign hdr_stat = ~hdr_ctrl & cfg_stat_on_focus & (hdr_q[HDR_BITS-1 -: DAC_AW] == FOCUS_ADDR);
  assign tx_want  = hdr_rd | hdr_stat;
  assign rd_addr  = {CTRL_TAG, hdr_off};

  always_comb begin
    if (!hdr_rd)                  tx_src = status_i;
    else if (hdr_off == LOCK_OFF) tx_src = {unlock_q, {(DATA_W-1){1'b0}}};
    else                          tx_src = rd_data;
  end

  assign tx_load  = tx_want & (cfg_adv_rd ? hdr_vld
                                          : (sel_act & sclk_fall & (bit_cnt == CNT_HDR)));
  assign tx_shift = sel_act & (cfg_adv_rd ? sclk_rise : (sclk_fall & (bit_cnt > CNT_HDR)));

  spi_somi_tx #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .stop(~sel_act), .load(tx_load), .load_data(tx_src),
    .shift(tx_shift), .bit_o(somi), .oe_o(somi_oe)
  );

  assign somi_pd_en = cfg_idle_pull & ~somi_oe;

  // commit of accepted packets
  logic       pkt_ctrl, ctrl_wr, lock_hit, pending;
  logic [4:0] pkt_off;

  assign pkt_ctrl = is_ctrl(pkt_q[PKT_BITS-1 -: 2]);
  assign pkt_off  = pkt_q[12:8];
  assign ctrl_wr  = pkt_ctrl & ~pkt_q[13];
  assign lock_hit = ctrl_wr & (pkt_off == LOCK_OFF);
  assign pending  = wr_valid & ~wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      wr_valid <= 1'b0;
      wr_dac   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (pkt_vld) begin
        if (lock_hit) begin
          unlock_q <= pkt_q[DATA_W-1];
        end else if (unlock_q && (ctrl_wr || !pkt_ctrl) && !pending) begin
          wr_valid <= 1'b1;
          wr_dac   <= ~pkt_ctrl;
          wr_addr  <= pkt_ctrl ? {CTRL_TAG, pkt_off} : {3'b000, pkt_q[PKT_BITS-1 -: DAC_AW]};
          wr_data  <= pkt_ctrl ? DAC_W'(pkt_q[DATA_W-1:0]) : pkt_q[DAC_W-1:0];
        end
      end
    end
  end

  spi_bus_wdog #(.LIM_LONG(WD_LONG), .LIM_MID(WD_MID), .LIM_SHORT(WD_SHORT)) u_wd (
    .clk(clk), .rst_n(rst_n), .sel(cfg_wd_sel), .busy(sel_act), .expire(wd_expire)
  );
endmodule

// File: rtl/drv_spi_slave_chk.sv
module drv_spi_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_dac,
  input logic [6:0]  wr_addr,
  input logic [11:0] wr_data,
  input logic        somi_oe,
  input logic        somi_pd_en,
  input logic        wd_expire,
  input logic [1:0]  cfg_wd_sel,
  input logic        ssz_lvl
);
  p_hold_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_dac));

  p_pull_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(somi_oe && somi_pd_en));

  p_expire_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !wd_expire);

  p_wd_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wd_sel == 2'd0 && $past(cfg_wd_sel) == 2'd0 |-> !wd_expire);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ssz_lvl && $past(ssz_lvl) |-> !somi_oe);
endmodule

bind drv_spi_slave drv_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_dac(wr_dac), .wr_addr(wr_addr), .wr_data(wr_data), .somi_oe(somi_oe),
  .somi_pd_en(somi_pd_en), .wd_expire(wd_expire), .cfg_wd_sel(cfg_wd_sel),
  .ssz_lvl(ssz_lvl)
);

// File: tb/drv_spi_slave_tb_top.sv
module drv_spi_slave_tb_top;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ssz_n = 1'b1, sclk = 1'b0, simo = 1'b0;
  logic somi, somi_oe, somi_pd_en;
  logic cfg_adv_rd = 1'b0, cfg_stat_on_focus = 1'b0, cfg_idle_pull = 1'b0;
  logic [1:0] cfg_wd_sel = 2'd0;
  logic [7:0] status_i = 8'h00;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  logic wr_valid, wr_ready = 1'b1, wr_dac;
  logic [6:0] wr_addr;
  logic [11:0] wr_data;
  logic wd_expire;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, exp_cnt = 0;
  logic [6:0] last_addr;
  logic [11:0] last_data;
  logic last_dac;

  always #10 clk = ~clk;

  function automatic logic [7:0] rd_model(input logic [6:0] a);
    return {a, 1'b0} ^ 8'hA5;
  endfunction
  assign rd_data = rd_model(rd_addr);

  drv_spi_slave dut_i (
    .clk(clk), .rst_n(rst_n), .ssz_n(ssz_n), .sclk(sclk), .simo(simo),
    .somi(somi), .somi_oe(somi_oe), .somi_pd_en(somi_pd_en),
    .cfg_adv_rd(cfg_adv_rd), .cfg_stat_on_focus(cfg_stat_on_focus),
    .cfg_idle_pull(cfg_idle_pull), .cfg_wd_sel(cfg_wd_sel), .status_i(status_i),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_dac(wr_dac), .wr_addr(wr_addr), .wr_data(wr_data), .wd_expire(wd_expire)
  );

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      wr_cnt++;
      last_addr = wr_addr; last_data = wr_data; last_dac = wr_dac;
    end
    if (rst_n && wd_expire) exp_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nclk, output logic [7:0] rx, output logic oe_mid);
    rx = 8'h00; oe_mid = 1'b0;
    ssz_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      simo = (i < 16) ? w[15-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i >= 8 && i < 16) rx = {rx[6:0], somi_oe ? somi : 1'b0};
      sclk = 1'b1;
      repeat (HP/2) @(negedge clk);
      if (i == 7) oe_mid = somi_oe;
      repeat (HP/2) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    ssz_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrl_w(input bit rd, input logic [4:0] off, input logic [7:0] d);
    return {2'b11, rd, off, d};
  endfunction

  // DAC write: checks committed write fields
  task automatic dac_write(input logic [3:0] a, input logic [11:0] d, input string req);
    logic [7:0] rx; logic om; int c0;
    c0 = wr_cnt;
    xfer({a, d}, 16, rx, om);
    chk(wr_cnt == c0 + 1, req, wr_cnt - c0, 1);
    chk(last_dac && last_addr == {3'b0, a} && last_data == d, req,
        {last_dac, last_addr, last_data}, {1'b1, 3'b0, a, d});
  endtask

  initial begin : watchdog_timer
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] rx; logic om; int c0; int e0;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk(!wr_valid, "R9 reset wr_valid", wr_valid, 0);
    chk(!somi_oe, "R5 reset somi_oe", somi_oe, 0);
    chk(!somi_pd_en, "R8 reset pd", somi_pd_en, 0);
    chk(!wd_expire, "R10 reset expire", wd_expire, 0);

    // R4 locked after reset
    c0 = wr_cnt;
    xfer({4'h5, 12'h123}, 16, rx, om);
    chk(wr_cnt == c0, "R4 locked dac write dropped", wr_cnt - c0, 0);
    xfer(ctrl_w(1'b0, 5'h03, 8'h44), 16, rx, om);
    chk(wr_cnt == c0, "R4 locked ctrl write dropped", wr_cnt - c0, 0);
    xfer(ctrl_w(1'b1, 5'h16, 8'h00), 16, rx, om);
    chk(rx == 8'h00, "R4 lock bit reads 0", rx, 0);
    chk(wr_cnt == c0, "R11 read no write", wr_cnt - c0, 0);

    // R4 unlock
    xfer(ctrl_w(1'b0, 5'h16, 8'h80), 16, rx, om);
    chk(wr_cnt == c0, "R4 lock write not forwarded", wr_cnt - c0, 0);
    xfer(ctrl_w(1'b1, 5'h16, 8'h00), 16, rx, om);
    chk(rx == 8'h80, "R4 lock bit reads 1", rx, 8'h80);

    // R1 R3 directed writes
    dac_write(4'h5, 12'hABC, "R1 R3 dac write");
    c0 = wr_cnt;
    xfer(ctrl_w(1'b0, 5'h0F, 8'h5A), 16, rx, om);
    chk(wr_cnt == c0 + 1 && !last_dac && last_addr == 7'h6F && last_data == 12'h05A,
        "R3 ctrl write", {last_dac, last_addr, last_data}, {1'b0, 7'h6F, 12'h05A});

    // R2 wrong lengths
    c0 = wr_cnt;
    xfer({4'h1, 12'h111}, 15, rx, om);
    chk(wr_cnt == c0, "R2 15 clocks dropped", wr_cnt - c0, 0);
    xfer({4'h1, 12'h222}, 17, rx, om);
    chk(wr_cnt == c0, "R2 17 clocks dropped", wr_cnt - c0, 0);
    dac_write(4'h1, 12'h333, "R2 16 clocks after bad frames");

    // random mix
    for (int k = 0; k < 40; k++) begin
      int kind; logic [4:0] off; logic [11:0] d; logic [3:0] a;
      kind = $urandom_range(0, 2);
      cfg_adv_rd = 1'($urandom_range(0, 1));
      d = 12'($urandom);
      off = 5'($urandom_range(0, 31));
      if (off == 5'h16) off = 5'h15;
      a = 4'($urandom_range(0, 11));
      if (kind == 0) begin
        dac_write(a, d, "R3 random dac write");
      end else if (kind == 1) begin
        c0 = wr_cnt;
        xfer(ctrl_w(1'b0, off, d[7:0]), 16, rx, om);
        chk(wr_cnt == c0 + 1 && !last_dac && last_addr == {2'b11, off} && last_data == {4'h0, d[7:0]},
            "R3 random ctrl write", {last_dac, last_addr, last_data}, {1'b0, 2'b11, off, 4'h0, d[7:0]});
      end else begin
        c0 = wr_cnt;
        xfer(ctrl_w(1'b1, off, d[7:0]), 16, rx, om);
        chk(rx == rd_model({2'b11, off}), cfg_adv_rd ? "R6 random adv read" : "R5 random read",
            rx, rd_model({2'b11, off}));
        chk(om == cfg_adv_rd, "R6 drive start phase", om, cfg_adv_rd);
        chk(wr_cnt == c0, "R11 random read no write", wr_cnt - c0, 0);
      end
    end
    cfg_adv_rd = 1'b0;

    // R7 status readback on focus write
    cfg_stat_on_focus = 1'b1; status_i = 8'h3C;
    c0 = wr_cnt;
    xfer({4'h2, 12'h7E1}, 16, rx, om);
    chk(rx == 8'h3C, "R7 status on focus", rx, 8'h3C);
    chk(wr_cnt == c0 + 1 && last_addr == 7'h02 && last_data == 12'h7E1, "R7 focus write kept",
        {last_addr, last_data}, {7'h02, 12'h7E1});
    cfg_adv_rd = 1'b1; status_i = 8'hC5;
    xfer({4'h2, 12'h001}, 16, rx, om);
    chk(rx == 8'hC5, "R7 R6 status adv", rx, 8'hC5);
    cfg_adv_rd = 1'b0;
    xfer({4'h3, 12'h001}, 16, rx, om);
    chk(rx == 8'h00, "R7 other addr silent", rx, 0);
    cfg_stat_on_focus = 1'b0;
    xfer({4'h2, 12'h002}, 16, rx, om);
    chk(rx == 8'h00, "R7 option off silent", rx, 0);

    // R8 idle pull
    cfg_idle_pull = 1'b1;
    repeat (2) @(negedge clk);
    chk(somi_pd_en, "R8 idle pull on", somi_pd_en, 1);

    // R9 back-pressure
    wr_ready = 1'b0;
    c0 = wr_cnt;
    xfer({4'h4, 12'h444}, 16, rx, om);
    chk(wr_valid && wr_addr == 7'h04 && wr_data == 12'h444, "R9 held under stall",
        {wr_valid, wr_addr, wr_data}, {1'b1, 7'h04, 12'h444});
    xfer({4'h6, 12'h666}, 16, rx, om);
    chk(wr_valid && wr_data == 12'h444, "R9 second write dropped", wr_data, 12'h444);
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_cnt == c0 + 1 && last_data == 12'h444 && !wr_valid, "R9 accepted once",
        wr_cnt - c0, 1);

    // R4 relock
    xfer(ctrl_w(1'b0, 5'h16, 8'h00), 16, rx, om);
    c0 = wr_cnt;
    xfer({4'h7, 12'h777}, 16, rx, om);
    chk(wr_cnt == c0, "R4 relocked dropped", wr_cnt - c0, 0);

    // R10 watchdog
    cfg_wd_sel = 2'd3;
    xfer(ctrl_w(1'b1, 5'h01, 8'h00), 16, rx, om);
    e0 = exp_cnt;
    repeat (400) @(negedge clk);
    chk(exp_cnt == e0, "R10 short not yet", exp_cnt - e0, 0);
    repeat (300) @(negedge clk);
    chk(exp_cnt == e0 + 1, "R10 short expired once", exp_cnt - e0, 1);
    cfg_wd_sel = 2'd2;
    xfer(ctrl_w(1'b1, 5'h01, 8'h00), 16, rx, om);
    e0 = exp_cnt;
    repeat (4800) @(negedge clk);
    chk(exp_cnt == e0, "R10 medium not yet", exp_cnt - e0, 0);
    repeat (400) @(negedge clk);
    chk(exp_cnt == e0 + 1, "R10 medium expired", exp_cnt - e0, 1);
    cfg_wd_sel = 2'd0;
    e0 = exp_cnt;
    repeat (6000) @(negedge clk);
    chk(exp_cnt == e0, "R10 off silent", exp_cnt - e0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule